// File: doc/BRIEF.md
# Video Sync Output Conditioner

This block sits behind a sync separator and reshapes the sync signals sent to the rest of a video capture path. Its inputs are a horizontal sync, a raw vertical sync from an integrator, and a coast signal, all sampled on the pixel clock. The lock edge is the rising edge of `hsync_in`: the first sample that is high after a low one.

From these inputs the block produces four outputs:
- a horizontal pulse of programmable width, placed so that either its leading edge or its trailing edge falls on the lock edge;
- a vertical sync that is either retimed to that pulse or passed through raw;
- the coast signal, with its polarity normalised;
- a pin output that carries either the vertical sync or the coast signal.

Trailing-edge placement needs the pulse to start before the lock edge that ends it. The block therefore measures the line period between lock edges and starts the pulse at that predicted period minus the width.

A control word and a width value are written through simple strobes. Both are held in shadow registers and take effect together at the next lock edge, so a pulse never uses a half-applied setting. The four outputs share one enable, `sync_oe`, which stands for driving the pads versus leaving them at high impedance.

Control word bits:

| Bit | Meaning |
|-----|---------|
| 0 | outputs off |
| 1 | coast inverted |
| 2 | leading-edge lock |
| 3, 5, 6 | reserved, must be 0 |
| 4 | raw vertical |
| 7 | coast on pin |

The horizontal pulse is generated by a state machine with three states:
- HS_ACQ: no line period is known yet. It holds until a lock edge arrives.
- HS_GAP: the output is low.
- HS_HIGH: the output is high.

Its transitions:
- Every lock edge goes to HS_HIGH if leading-edge lock is selected and the width is non-zero.
- Otherwise a lock edge goes to HS_GAP, or to HS_ACQ when it is the first lock edge since reset in trailing mode.
- With no lock edge, HS_GAP goes to HS_HIGH when the trailing start count is reached.
- With no lock edge, HS_HIGH goes to HS_GAP when the leading-mode width counter expires.

Top module: `sync_out_cond`

## Requirements
- R1: `sync_oe` is 1 while control bit 0 is 0, which is its value after reset. Once a control word with bit 0 = 1 is in effect, `sync_oe` is 0.
- R2: `coast_out` equals `coast_in` delayed by one clock when control bit 1 is 0, and its inverse when bit 1 is 1.
- R3: With control bit 2 = 1 (leading-edge lock), `hs_out` rises on the clock edge that samples the lock edge. It then stays high for exactly W clocks, where W is the width value.
- R4: With control bit 2 = 0 (trailing-edge lock), `hs_out` falls on the clock edge that samples the lock edge. It has been high for the W clocks before that edge, and its start is predicted from the period between the two previous lock edges.
- R5: In trailing-edge lock, `hs_out` stays low until two lock edges have been seen since reset.
- R6: A width of 0 keeps `hs_out` low in both modes. A width must be smaller than the line period in clocks.
- R7: With control bit 4 = 0, `vs_out` changes only on the clock where `hs_out` makes its active edge: rising in leading mode, falling in trailing mode. At that edge it takes the value of `vsync_in`.
- R8: With control bit 4 = 1, `vs_out` equals `vsync_in` delayed by one clock.
- R9: `vpin_out` follows `vs_out` when control bit 7 is 0 and `coast_out` when it is 1.
- R10: The control word and the width both reset to 0. A value written through `ctrl_we` or `width_we` has no effect until the clock that samples the next lock edge.
- R11: Reserved control bits 3, 5 and 6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| hsync_in | input | 1 | incoming horizontal sync, rising edge is the lock edge |
| vsync_in | input | 1 | raw integrator vertical sync |
| coast_in | input | 1 | coast request at its programmed polarity |
| ctrl_we | input | 1 | control word write strobe |
| ctrl_wdata | input | 8 | control word |
| width_we | input | 1 | pulse width write strobe |
| width_wdata | input | WID_W | pulse width in pixel clocks |
| hs_out | output | 1 | conditioned horizontal pulse |
| vs_out | output | 1 | conditioned vertical sync |
| coast_out | output | 1 | coast, active high |
| vpin_out | output | 1 | selected vertical pin output |
| sync_oe | output | 1 | drive enable for the four sync outputs |

## Verification
The assertions check four things on every clock:
- settings change only at lock edges;
- the output enable moves only there;
- a retimed vertical sync never moves without an edge of `hs_out`;
- in trailing mode the pulse never appears before a period is known and is held until the lock edge, and a zero width keeps it low.

The exact pulse position, its width and the retimed value need the bench's scenarios. Those scenarios are trains of lines with known period and width, measured against the lock edge in both modes, including a width of one less than the period. The bench also writes settings in mid-line and sets reserved bits.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;

    typedef struct packed {
        logic pin_coast;
        logic rsv6;
        logic rsv5;
        logic vs_raw;
        logic rsv3;
        logic lead_lock;
        logic coast_inv;
        logic out_off;
    } ctrl_t;

    localparam logic [7:0] CTRL_LIVE_MASK = 8'h97;

    typedef enum logic [1:0] {
        HS_ACQ  = 2'd0,
        HS_GAP  = 2'd1,
        HS_HIGH = 2'd2
    } hs_state_t;

endpackage

// File: rtl/sync_ctrl_regs.sv
module sync_ctrl_regs
    import sync_cond_pkg::*;
#(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             width_we,
    input  logic [WID_W-1:0] width_wdata,
    output ctrl_t            cfg_act,
    output ctrl_t            cfg_eff,
    output logic [WID_W-1:0] wid_eff
);

    ctrl_t            cfg_pend;
    logic [WID_W-1:0] wid_pend;
    logic [WID_W-1:0] wid_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_pend <= '0;
            wid_pend <= '0;
        end else begin
            if (ctrl_we)  cfg_pend <= ctrl_t'(ctrl_wdata & CTRL_LIVE_MASK);
            if (width_we) wid_pend <= width_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_act <= '0;
            wid_act <= '0;
        end else if (lock) begin
            cfg_act <= cfg_pend;
            wid_act <= wid_pend;
        end
    end

    assign cfg_eff = lock ? cfg_pend : cfg_act;
    assign wid_eff = lock ? wid_pend : wid_act;

    // R10: settings in use only change at a lock edge
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> ($stable(cfg_act) && $stable(wid_act)));

endmodule

// File: rtl/sync_line_timer.sv
module sync_line_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic             armed
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            period <= '0;
            armed  <= 1'b0;
        end else if (lock) begin
            cnt    <= '0;
            period <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
            armed  <= 1'b1;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sync_hpulse_fsm.sv
module sync_hpulse_fsm
    import sync_cond_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             lead,
    input  logic [WID_W-1:0] width,
    input  logic             armed,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cnt,
    output logic             hs_high,
    output logic             act_edge
);

    hs_state_t        state, state_n;
    logic [WID_W-1:0] wcnt;
    logic [CNT_W-1:0] wid_x;
    logic             start_trail;

    assign wid_x = CNT_W'(width);
    assign start_trail = !lead && (width != '0) && (wid_x < period)
                         && (cnt == period - wid_x - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_ACQ;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (lock) begin
            if (lead)       state_n = (width != '0) ? HS_HIGH : HS_GAP;
            else if (armed) state_n = HS_GAP;
            else            state_n = HS_ACQ;
        end else begin
            unique case (state)
                HS_ACQ:  state_n = HS_ACQ;
                HS_GAP:  if (start_trail) state_n = HS_HIGH;
                HS_HIGH: if (lead && wcnt == '0) state_n = HS_GAP;
                default: state_n = HS_ACQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     wcnt <= '0;
        else if (lock)                  wcnt <= width - 1'b1;
        else if (state == HS_HIGH && wcnt != '0) wcnt <= wcnt - 1'b1;
    end

    always_comb begin
        hs_high  = (state == HS_HIGH);
        act_edge = lead ? (state != HS_HIGH && state_n == HS_HIGH)
                        : (state == HS_HIGH && state_n != HS_HIGH);
    end

    // R3: a non-zero width in leading mode starts the pulse at the lock edge
    a_r3_lead_start: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && lead && width != '0) |=> hs_high);
    // R4: in trailing mode the pulse is held until a lock edge ends it
    a_r4_trail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_high && !lead && !lock) |=> hs_high);
    // R5: no trailing pulse before a period has been measured
    a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !lead) |=> !hs_high);
    // R6: zero width suppresses the pulse
    a_r6_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && width == '0) |=> !hs_high);

endmodule

// File: rtl/sync_out_cond.sv
module sync_out_cond
    import sync_cond_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             coast_in,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             width_we,
    input  logic [WID_W-1:0] width_wdata,
    output logic             hs_out,
    output logic             vs_out,
    output logic             coast_out,
    output logic             vpin_out,
    output logic             sync_oe
);

    logic             hs_prev, lock;
    ctrl_t            cfg_act, cfg_eff;
    logic [WID_W-1:0] wid_eff;
    logic [CNT_W-1:0] cnt, period;
    logic             armed, hs_edge;
    logic             vs_ret, vs_raw_q, coast_q;

    always_ff @(posedge clk) begin
        if (!rst_n) hs_prev <= 1'b0;
        else        hs_prev <= hsync_in;
    end
    assign lock = hsync_in && !hs_prev;

    sync_ctrl_regs #(.WID_W(WID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .width_we(width_we), .width_wdata(width_wdata),
        .cfg_act(cfg_act), .cfg_eff(cfg_eff), .wid_eff(wid_eff)
    );

    sync_line_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .cnt(cnt), .period(period), .armed(armed)
    );

    sync_hpulse_fsm #(.CNT_W(CNT_W), .WID_W(WID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lock(lock),
        .lead(cfg_eff.lead_lock), .width(wid_eff),
        .armed(armed), .period(period), .cnt(cnt),
        .hs_high(hs_out), .act_edge(hs_edge)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_ret   <= 1'b0;
            vs_raw_q <= 1'b0;
            coast_q  <= 1'b0;
        end else begin
            if (hs_edge) vs_ret <= vsync_in;
            vs_raw_q <= vsync_in;
            coast_q  <= coast_in ^ cfg_eff.coast_inv;
        end
    end

    assign vs_out    = cfg_act.vs_raw ? vs_raw_q : vs_ret;
    assign coast_out = coast_q;
    assign vpin_out  = cfg_act.pin_coast ? coast_q : vs_out;
    assign sync_oe   = !cfg_act.out_off;

    // R1: the output enable only moves at a lock edge
    a_r1_oe_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_oe) |-> $past(lock));
    // R7: a retimed vertical sync never moves without an edge on hs_out
    a_r7_vs_retime: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_act.vs_raw && $stable(cfg_act) && $stable(hs_out)) |-> $stable(vs_out));

endmodule

// File: tb/sim_sync_out_cond.sv
module sim_sync_out_cond;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, coast_in = 1'b0;
    logic       ctrl_we = 1'b0, width_we = 1'b0;
    logic [7:0] ctrl_wdata = '0, width_wdata = '0;
    logic       hs_out, vs_out, coast_out, vpin_out, sync_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the settings
    logic [7:0] pend, act;
    int         wpend, wact, P;
    logic       vs_exp;
    bit         rsv_scn, wr_scn;

    always #2 clk = ~clk;

    sync_out_cond u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .coast_in(coast_in), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .width_we(width_we), .width_wdata(width_wdata),
        .hs_out(hs_out), .vs_out(vs_out), .coast_out(coast_out),
        .vpin_out(vpin_out), .sync_oe(sync_oe)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, got, exp);
        end
    endtask

    function automatic logic exp_hs(input int line, input int idx);
        if (line < 0 || wact == 0) return 1'b0;
        if (act[2]) return idx < wact;
        return (line >= 1) && (idx >= P - wact);
    endfunction

    function automatic string hs_tag(input int line);
        if (rsv_scn)   return "R11 hs";
        if (wact == 0) return "R6 hs";
        if (act[2])    return "R3 hs";
        if (line < 1)  return "R5 hs";
        return "R4 hs";
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; hsync_in = 0; vsync_in = 0; coast_in = 0;
        ctrl_we = 0; width_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pend = '0; act = '0; wpend = 0; wact = 0; vs_exp = 1'b0;
        chk("R10 reset hs", hs_out, 1'b0);
        chk("R10 reset vs", vs_out, 1'b0);
        chk("R10 reset oe", sync_oe, 1'b1);
        chk("R10 reset coast", coast_out, 1'b0);
    endtask

    task automatic step(input logic hs, input logic vs, input logic co,
                        input logic cwe, input logic [7:0] cval,
                        input logic wwe, input logic [7:0] wval,
                        input int line, input int idx);
        logic vsx, cox;
        hsync_in = hs; vsync_in = vs; coast_in = co;
        ctrl_we = cwe; ctrl_wdata = cval; width_we = wwe; width_wdata = wval;
        @(posedge clk);
        if (line >= 0 && idx == 0) begin
            act = pend; wact = wpend;
            if (act[2] ? (wact != 0) : (line >= 2 && wact != 0)) vs_exp = vs;
        end
        if (cwe) pend = cval & 8'h97;
        if (wwe) wpend = int'(wval);
        @(negedge clk);
        ctrl_we = 0; width_we = 0;
        vsx = act[4] ? vs : vs_exp;
        cox = co ^ act[1];
        chk(hs_tag(line), hs_out, exp_hs(line, idx));
        chk(act[4] ? "R8 vs" : "R7 vs", vs_out, vsx);
        chk("R2 coast", coast_out, cox);
        chk("R9 pin", vpin_out, act[7] ? cox : vsx);
        chk(wr_scn ? "R10 oe" : "R1 oe", sync_oe, !act[0]);
    endtask

    task automatic run_scn(input logic [7:0] cfg, input int w, input int p,
                           input int nl, input int wr_line, input logic [7:0] wr_val,
                           input bit rsv);
        logic vcur = 1'b0;
        do_reset();
        P = p; rsv_scn = rsv; wr_scn = (wr_line >= 0);
        step(0, 0, 0, 1, cfg, 1, w[7:0], -1, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, -1, 0);
        for (int n = 0; n < nl; n++) begin
            for (int i = 0; i < p; i++) begin
                if ($urandom % 6 == 0) vcur = ~vcur;
                step(i < 2, vcur, 1'($urandom % 2),
                     (n == wr_line && i == p / 2), wr_val, 0, 0, n, i);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed corner cases
        run_scn(8'h04, 1, 12, 4, -1, 0, 0);     // R3 single-clock leading pulse
        run_scn(8'h00, 11, 12, 4, -1, 0, 0);    // R4 width one below period
        run_scn(8'h00, 5, 20, 5, -1, 0, 0);     // R4 R5 trailing, R7 retime on fall
        run_scn(8'h04, 0, 16, 3, -1, 0, 0);     // R6 zero width leading
        run_scn(8'h00, 0, 16, 3, -1, 0, 0);     // R6 zero width trailing
        run_scn(8'h10, 4, 16, 3, -1, 0, 0);     // R8 raw vertical
        run_scn(8'h82, 3, 14, 3, -1, 0, 0);     // R9 coast on pin, R2 inverted
        run_scn(8'h6C, 6, 18, 4, -1, 0, 1);     // R11 reserved bits set
        run_scn(8'h00, 4, 16, 4, 2, 8'h01, 0);  // R10 mid-line write, R1 outputs off
        // constrained random lines
        for (int s = 0; s < 40; s++) begin
            int p = 8 + int'($urandom % 33);
            int w = int'($urandom % p);
            logic [7:0] c = 8'($urandom);
            run_scn(c, w, p, 2 + int'($urandom % 4), -1, 0, (c & 8'h68) != 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1-all: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule